// File: doc/BRIEF.md
# Space-Tagged Two-Way Hashed Translation Cache

This block holds recently used virtual-page-to-real-frame translations for a processor's address translation path. Every entry carries the address-space identifier it was created under. Translations for many spaces can therefore stay resident together, and nothing has to be flushed when the active space changes. A lookup presents a virtual page number and the current space identifier. One cycle later the block reports hit or miss and, on a hit, the real frame number. When a lookup misses, an external table walker produces the translation and writes it through the insert port.

The storage has two halves of equal depth: a primary half and an alternate half. Each half is addressed by its own XOR hash of the page number and the space identifier, so every translation has exactly two possible homes. One recency bit per primary slot selects which home a new translation overwrites. Every entry has two banks of valid bits. A full purge switches to the spare bank, which is already empty, so the cache is empty from the next cycle. The abandoned bank is then cleared one slot per cycle in the background while lookups and inserts carry on. A space purge removes every entry of one identifier. Those entries stop hitting at once, and a background scan then clears their valid bits.

Top module: `xlat_cache`

## Requirements
- R1: After reset, `rsp_valid` is 0, `cmd_ready` is 1, and every lookup misses.
- R2: Lookup timing. A lookup presented in one cycle gives `rsp_valid`=1 in the next cycle, and only then. If a live entry matches both the page number and the space identifier, the response has `rsp_hit`=1 and `rsp_rfa` equal to the stored frame number.
- R3: A lookup misses when no live entry in its two candidate slots matches both the page number and the identifier. A matching page under another identifier does not hit, and neither does the same low page field with different upper page bits. On a miss, `rsp_rfa` is 0.
- R4: Slot hashing (default widths 13/8). Primary slot = `vpn[7:0] ^ sid`. Alternate slot = `rev(vpn[7:0]) ^ rotl(sid,3)`, where `rev` reverses bit order so that bit i takes bit 7-i, and `rotl(s,3)` is `{s[4:0],s[7:5]}`. In `sid`, bit 7 is the reuse flipper and bits 6:0 are the slot number; the block treats all 8 bits as one identifier.
- R5: Victim choice for an insert with no existing match. A free primary slot is used first. Otherwise a free alternate slot is used. If both are taken, the less recently used of the two is overwritten.
- R6: Recency tracking. The recency bit is indexed by the primary slot of the access. It marks the primary slot as recent when a lookup hits there or an insert writes there. It marks the alternate slot as recent when a lookup hits in the alternate slot or an insert writes there. If an insert and a lookup in the same cycle touch the same bit, the insert decides its value.
- R7: Full purge. When `purge_all` is accepted with `cmd_ready`=1, every lookup presented from the next cycle on misses. `cmd_ready` is then 0 for exactly 256 cycles. A purge command raised while `cmd_ready` is 0 has no effect.
- R8: Lookups and inserts continue during the background clear. A translation inserted after a full purge hits normally, and a translation from before the purge never reappears after later purges.
- R9: Space purge. When `purge_space` is accepted, every entry tagged `purge_sid` misses from the next cycle on, and entries of other identifiers keep hitting. `cmd_ready` is 0 for 256 cycles. The purged identifier must not be inserted again until `cmd_ready` returns. If both purge inputs are raised together, the full purge is taken.
- R10: An insert whose page and identifier already live in one of its two candidate slots overwrites that slot in place, so the new frame number is returned afterwards and no duplicate exists.
- R11: State updates take effect at the clock edge. A lookup in the same cycle as an insert or a purge sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 13 | Virtual page number to translate |
| lk_sid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_rfa | output | 12 | Real frame number on a hit, 0 on a miss |
| ins_req | input | 1 | Insert a translation |
| ins_vpn | input | 13 | Page number of the new translation |
| ins_sid | input | 8 | Identifier of the new translation |
| ins_rfa | input | 12 | Frame number of the new translation |
| purge_all | input | 1 | Invalidate every entry |
| purge_space | input | 1 | Invalidate the entries of one identifier |
| purge_sid | input | 8 | Identifier for a space purge |
| cmd_ready | output | 1 | High when a purge command can be accepted |

## Verification
A wrong victim choice or a wrong recency bit is silent until a later access. It shows up as a miss where a hit was expected, or as a stale hit, on a following lookup of the evicted or surviving translation. The bench therefore runs a full reference of both halves and compares every response. A background clear that leaves stale valid bits stays hidden until the bank is reused. It appears as an old translation that hits again after the second full purge, about 257 or more cycles later. A wrong scan length shows directly on `cmd_ready` at the cycle where it should rise.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
    // Background scan activity of the purge sequencer
    typedef enum logic [1:0] {
        SCAN_IDLE  = 2'd0,
        SCAN_FULL  = 2'd1,
        SCAN_SPACE = 2'd2
    } scan_mode_t;
endpackage

// File: rtl/xlc_hash.sv
// Slot hash for one half of the translation cache.
// ALT=0: idx[i] = vpn[i] ^ sid[i mod SID_W].
// ALT=1: idx[i] = vpn[IDX_W-1-i] ^ rotl(sid,ROT)[i mod SID_W].
// Assumes the caller passes only the low IDX_W page bits.
module xlc_hash #(
    parameter int IDX_W = 8,
    parameter int SID_W = 8,
    parameter int ROT   = 3,
    parameter bit ALT   = 1'b0
) (
    input  logic [IDX_W-1:0] vpn_lo,
    input  logic [SID_W-1:0] sid,
    output logic [IDX_W-1:0] idx
);
    localparam int ROT_M = ROT % SID_W;

    genvar i;
    generate
        for (i = 0; i < IDX_W; i++) begin : g_bit
            if (ALT) begin : g_alt
                // reversed page bit folded with the rotated identifier
                assign idx[i] = vpn_lo[IDX_W-1-i] ^ sid[(i + SID_W - ROT_M) % SID_W];
            end else begin : g_pri
                // straight page bit folded with the identifier
                assign idx[i] = vpn_lo[i] ^ sid[i % SID_W];
            end
        end
    endgenerate
endmodule

// File: rtl/xlc_scrub.sv
// Purge sequencer. A full purge flips the active valid bank at once and
// then clears the abandoned bank one slot per cycle. A space purge
// latches the identifier, asks the halves to hide its entries, and clears
// matching slots one per cycle. Only one scan runs at a time; cmd_ready is
// low while a scan runs. Full purge wins over a space purge in the same cycle.
module xlc_scrub
    import xlc_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int SID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_req,
    input  logic             space_req,
    input  logic [SID_W-1:0] space_sid,
    output logic             ready,
    output logic             bank,
    output logic             clr_en,
    output logic             clr_full,
    output logic             clr_bank,
    output logic [IDX_W-1:0] clr_idx,
    output logic [SID_W-1:0] scan_sid,
    output logic             sup_en
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    scan_mode_t       mode_q;
    logic             bank_q;
    logic [IDX_W-1:0] idx_q;
    logic [SID_W-1:0] sid_q;

    // Command acceptance, bank flip and scan stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SCAN_IDLE;
            bank_q <= 1'b0;
            idx_q  <= '0;
            sid_q  <= '0;
        end else begin
            case (mode_q)
                SCAN_IDLE: begin
                    if (full_req) begin
                        bank_q <= ~bank_q;
                        mode_q <= SCAN_FULL;
                        idx_q  <= '0;
                    end else if (space_req) begin
                        sid_q  <= space_sid;
                        mode_q <= SCAN_SPACE;
                        idx_q  <= '0;
                    end
                end
                default: begin
                    if (idx_q == LAST_IDX) begin
                        mode_q <= SCAN_IDLE;
                    end
                    idx_q <= idx_q + 1'b1;
                end
            endcase
        end
    end

    // Decoded controls for the two halves
    always_comb begin
        ready    = (mode_q == SCAN_IDLE);
        bank     = bank_q;
        clr_en   = (mode_q != SCAN_IDLE);
        clr_full = (mode_q == SCAN_FULL);
        clr_bank = ~bank_q;
        clr_idx  = idx_q;
        scan_sid = sid_q;
        sup_en   = (mode_q == SCAN_SPACE);
    end

    AST_FULL_FLIPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (full_req && ready) |=> (bank != $past(bank)));                 // R7
    AST_CMD_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((full_req || space_req) && ready) |=> !ready);                 // R9
    AST_BANK_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(bank));                                      // R7
endmodule

// File: rtl/xlc_half.sv
// One half of the translation cache: DEPTH slots of page, identifier and
// frame, plus two banks of valid bits. It has two read ports (lookup and
// insert) that report a live match. A slot counts as live when its bit in
// the active bank is set and it is not hidden by a running space purge.
// It has one write port and one clear port driven by the purge sequencer.
// Assumes bank does not change while a space scan runs.
module xlc_half #(
    parameter int IDX_W = 8,
    parameter int VPN_W = 13,
    parameter int SID_W = 8,
    parameter int RFA_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [SID_W-1:0] lk_sid,
    output logic             lk_hit,
    output logic [RFA_W-1:0] lk_rfa,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [VPN_W-1:0] in_vpn,
    input  logic [SID_W-1:0] in_sid,
    output logic             in_live,
    output logic             in_match,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [SID_W-1:0] wr_sid,
    input  logic [RFA_W-1:0] wr_rfa,
    input  logic             sup_en,
    input  logic [SID_W-1:0] sup_sid,
    input  logic             clr_en,
    input  logic             clr_full,
    input  logic             clr_bank,
    input  logic [IDX_W-1:0] clr_idx
);
    localparam int DEPTH = 1 << IDX_W;

    logic [VPN_W-1:0] vpn_q [DEPTH];
    logic [SID_W-1:0] sid_q [DEPTH];
    logic [RFA_W-1:0] rfa_q [DEPTH];
    logic [DEPTH-1:0] vld_q [2];
    logic             lk_live;

    // Entry payload write (no reset needed: guarded by valid bits)
    always_ff @(posedge clk) begin
        if (wr_en) begin
            vpn_q[in_idx] <= wr_vpn;
            sid_q[in_idx] <= wr_sid;
            rfa_q[in_idx] <= wr_rfa;
        end
    end

    // Valid banks: reset, background clear, then insert (insert wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= '0;
            vld_q[1] <= '0;
        end else begin
            if (clr_en) begin
                if (clr_full) begin
                    vld_q[clr_bank][clr_idx] <= 1'b0;
                end else if (sid_q[clr_idx] == sup_sid) begin
                    vld_q[bank][clr_idx] <= 1'b0;
                end
            end
            if (wr_en) begin
                vld_q[bank][in_idx] <= 1'b1;
            end
        end
    end

    // Lookup port compare
    always_comb begin
        lk_live = vld_q[bank][lk_idx] && !(sup_en && (sid_q[lk_idx] == sup_sid));
        lk_hit  = lk_live && (vpn_q[lk_idx] == lk_vpn) && (sid_q[lk_idx] == lk_sid);
        lk_rfa  = rfa_q[lk_idx];
    end

    // Insert port occupancy and match
    always_comb begin
        in_live  = vld_q[bank][in_idx] && !(sup_en && (sid_q[in_idx] == sup_sid));
        in_match = in_live && (vpn_q[in_idx] == in_vpn) && (sid_q[in_idx] == in_sid);
    end

    AST_WRITE_MAKES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sup_en) |=> vld_q[$past(bank)][$past(in_idx)]);     // R2
    AST_FULL_CLEAR_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_full) |=> !vld_q[$past(clr_bank)][$past(clr_idx)]); // R8
endmodule

// File: rtl/xlat_cache.sv
// Address-space-tagged translation cache with two hashed halves.
// Lookup: both halves are read combinationally and the response is
// registered, giving one cycle of latency. Insert: overwrite a matching
// slot, else fill a free slot (primary first), else evict the colder
// of the two candidates, as kept by one recency bit per primary slot.
// Purges go through xlc_scrub. Assumes the walker inserts only after a miss
// and never inserts an identifier that is being purged.
module xlat_cache #(
    parameter int IDX_W = 8,
    parameter int VPN_W = 13,
    parameter int SID_W = 8,
    parameter int RFA_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [SID_W-1:0] lk_sid,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [RFA_W-1:0] rsp_rfa,
    input  logic             ins_req,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [SID_W-1:0] ins_sid,
    input  logic [RFA_W-1:0] ins_rfa,
    input  logic             purge_all,
    input  logic             purge_space,
    input  logic [SID_W-1:0] purge_sid,
    output logic             cmd_ready
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int NHALF = 2;

    logic [IDX_W-1:0] lk_idx  [NHALF];
    logic [IDX_W-1:0] in_idx  [NHALF];
    logic             h_hit   [NHALF];
    logic [RFA_W-1:0] h_rfa   [NHALF];
    logic             h_live  [NHALF];
    logic             h_match [NHALF];
    logic             h_wr    [NHALF];

    logic             bank, clr_en, clr_full, clr_bank, sup_en;
    logic [IDX_W-1:0] clr_idx;
    logic [SID_W-1:0] scan_sid;
    logic [DEPTH-1:0] hot_q;     // 1: primary slot used more recently
    logic             hit_p, hit_a, vic_alt;

    xlc_scrub #(.IDX_W(IDX_W), .SID_W(SID_W)) u_scrub (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_req  (purge_all),
        .space_req (purge_space),
        .space_sid (purge_sid),
        .ready     (cmd_ready),
        .bank      (bank),
        .clr_en    (clr_en),
        .clr_full  (clr_full),
        .clr_bank  (clr_bank),
        .clr_idx   (clr_idx),
        .scan_sid  (scan_sid),
        .sup_en    (sup_en)
    );

    genvar h;
    generate
        for (h = 0; h < NHALF; h++) begin : g_half
            xlc_hash #(.IDX_W(IDX_W), .SID_W(SID_W), .ROT(3), .ALT(h == 1)) u_lk_hash (
                .vpn_lo (lk_vpn[IDX_W-1:0]),
                .sid    (lk_sid),
                .idx    (lk_idx[h])
            );
            xlc_hash #(.IDX_W(IDX_W), .SID_W(SID_W), .ROT(3), .ALT(h == 1)) u_in_hash (
                .vpn_lo (ins_vpn[IDX_W-1:0]),
                .sid    (ins_sid),
                .idx    (in_idx[h])
            );
            xlc_half #(.IDX_W(IDX_W), .VPN_W(VPN_W), .SID_W(SID_W), .RFA_W(RFA_W)) u_half (
                .clk      (clk),
                .rst_n    (rst_n),
                .bank     (bank),
                .lk_idx   (lk_idx[h]),
                .lk_vpn   (lk_vpn),
                .lk_sid   (lk_sid),
                .lk_hit   (h_hit[h]),
                .lk_rfa   (h_rfa[h]),
                .in_idx   (in_idx[h]),
                .in_vpn   (ins_vpn),
                .in_sid   (ins_sid),
                .in_live  (h_live[h]),
                .in_match (h_match[h]),
                .wr_en    (h_wr[h]),
                .wr_vpn   (ins_vpn),
                .wr_sid   (ins_sid),
                .wr_rfa   (ins_rfa),
                .sup_en   (sup_en),
                .sup_sid  (scan_sid),
                .clr_en   (clr_en),
                .clr_full (clr_full),
                .clr_bank (clr_bank),
                .clr_idx  (clr_idx)
            );
        end
    endgenerate

    // Lookup hit qualification
    always_comb begin
        hit_p = lk_req && h_hit[0];
        hit_a = lk_req && h_hit[1] && !h_hit[0];
    end

    // Victim selection: match, free primary, free alternate, then colder
    always_comb begin
        if (h_match[0])      vic_alt = 1'b0;
        else if (h_match[1]) vic_alt = 1'b1;
        else if (!h_live[0]) vic_alt = 1'b0;
        else if (!h_live[1]) vic_alt = 1'b1;
        else                 vic_alt = hot_q[in_idx[0]];
        h_wr[0] = ins_req && !vic_alt;
        h_wr[1] = ins_req && vic_alt;
    end

    // Registered lookup response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_rfa   <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= hit_p || hit_a;
            rsp_rfa   <= hit_p ? h_rfa[0] : (hit_a ? h_rfa[1] : '0);
        end
    end

    // Recency bits: lookup hit first, insert overrides
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_q <= '0;
        end else begin
            if (hit_p || hit_a) begin
                hot_q[lk_idx[0]] <= hit_p;
            end
            if (ins_req) begin
                hot_q[in_idx[0]] <= !vic_alt;
            end
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);                                          // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);                                        // R2
    AST_NO_DOUBLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> !(h_hit[0] && h_hit[1]));                            // R10
    AST_MISS_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(purge_all && cmd_ready) && lk_req) |=> !rsp_hit);        // R7
    AST_MISS_AFTER_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(purge_space && cmd_ready) && lk_req && (lk_sid == $past(purge_sid)))
        |=> !rsp_hit);                                                  // R9
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [12:0] lk_vpn = '0;
    logic [7:0]  lk_sid = '0;
    logic        rsp_valid, rsp_hit, cmd_ready;
    logic [11:0] rsp_rfa;
    logic        ins_req = 1'b0;
    logic [12:0] ins_vpn = '0;
    logic [7:0]  ins_sid = '0;
    logic [11:0] ins_rfa = '0;
    logic        purge_all = 1'b0, purge_space = 1'b0;
    logic [7:0]  purge_sid = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    bit          m_vld [2][256];
    logic [12:0] m_vpn [2][256];
    logic [7:0]  m_sid [2][256];
    logic [11:0] m_rfa [2][256];
    bit          m_hot [256];
    int          scan_left = 0;
    bit          scan_space = 1'b0;
    logic [7:0]  scan_sid = '0;

    always #(CLK_NS/2) clk = ~clk;

    xlat_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_sid(lk_sid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rfa(rsp_rfa),
        .ins_req(ins_req), .ins_vpn(ins_vpn), .ins_sid(ins_sid), .ins_rfa(ins_rfa),
        .purge_all(purge_all), .purge_space(purge_space), .purge_sid(purge_sid),
        .cmd_ready(cmd_ready)
    );

    function automatic logic [7:0] hpri(input logic [12:0] v, input logic [7:0] s);
        return v[7:0] ^ s;
    endfunction

    function automatic logic [7:0] halt(input logic [12:0] v, input logic [7:0] s);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r ^ {s[4:0], s[7:5]};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update the reference, check after the edge
    task automatic step(input bit lk, input logic [12:0] lv, input logic [7:0] ls,
                        input bit wi, input logic [12:0] wv, input logic [7:0] ws,
                        input logic [11:0] wr, input bit pa, input bit ps,
                        input logic [7:0] psd, input string tag);
        logic [7:0] pi, ai, qi, bi;
        bit hp, ha, e_hit, vic, acc, pm, am;
        logic [11:0] e_rfa;
        lk_req = lk; lk_vpn = lv; lk_sid = ls;
        ins_req = wi; ins_vpn = wv; ins_sid = ws; ins_rfa = wr;
        purge_all = pa; purge_space = ps; purge_sid = psd;
        pi = hpri(lv, ls); ai = halt(lv, ls);
        hp = lk && m_vld[0][pi] && m_vpn[0][pi] == lv && m_sid[0][pi] == ls;
        ha = lk && !hp && m_vld[1][ai] && m_vpn[1][ai] == lv && m_sid[1][ai] == ls;
        e_hit = hp || ha;
        e_rfa = hp ? m_rfa[0][pi] : (ha ? m_rfa[1][ai] : 12'h0);
        if (hp) m_hot[pi] = 1'b1; else if (ha) m_hot[pi] = 1'b0;
        if (wi) begin
            qi = hpri(wv, ws); bi = halt(wv, ws);
            pm = m_vld[0][qi] && m_vpn[0][qi] == wv && m_sid[0][qi] == ws;
            am = m_vld[1][bi] && m_vpn[1][bi] == wv && m_sid[1][bi] == ws;
            if (pm) vic = 1'b0;
            else if (am) vic = 1'b1;
            else if (!m_vld[0][qi]) vic = 1'b0;
            else if (!m_vld[1][bi]) vic = 1'b1;
            else vic = m_hot[qi];
            if (!vic) begin
                m_vld[0][qi] = 1'b1; m_vpn[0][qi] = wv; m_sid[0][qi] = ws; m_rfa[0][qi] = wr;
            end else begin
                m_vld[1][bi] = 1'b1; m_vpn[1][bi] = wv; m_sid[1][bi] = ws; m_rfa[1][bi] = wr;
            end
            m_hot[qi] = !vic;
        end
        acc = (scan_left == 0) && (pa || ps);
        if (acc) begin
            for (int h = 0; h < 2; h++)
                for (int k = 0; k < 256; k++)
                    if (pa || m_sid[h][k] == psd) m_vld[h][k] = 1'b0;
            scan_space = !pa;
            scan_sid = psd;
        end
        @(posedge clk);
        @(negedge clk);
        if (acc) scan_left = 256; else if (scan_left > 0) scan_left--;
        chk(rsp_valid == lk, tag, "rsp_valid", rsp_valid, lk);
        if (lk) begin
            chk(rsp_hit == e_hit, tag, "rsp_hit", rsp_hit, e_hit);
            chk(rsp_rfa == e_rfa, tag, "rsp_rfa", rsp_rfa, e_rfa);
        end
        chk(cmd_ready == (scan_left == 0), tag, "cmd_ready", cmd_ready, scan_left == 0);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic look(input logic [12:0] v, input logic [7:0] s, input string tag);
        step(1, v, s, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic put(input logic [12:0] v, input logic [7:0] s, input logic [11:0] r, input string tag);
        step(0, 0, 0, 1, v, s, r, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd7321));
        for (int h = 0; h < 2; h++)
            for (int k = 0; k < 256; k++) begin
                m_vld[h][k] = 1'b0; m_vpn[h][k] = '0; m_sid[h][k] = '0; m_rfa[h][k] = '0;
            end
        for (int k = 0; k < 256; k++) m_hot[k] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and empty cache
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
        look(13'h0012, 8'h05, "R1");
        look(13'h1abc, 8'h85, "R1");
        // R2 / R4: insert then hit
        put(13'h0012, 8'h05, 12'h111, "R2");
        look(13'h0012, 8'h05, "R2");
        // R3: other identifier, other upper page bits
        look(13'h0012, 8'h85, "R3");
        look(13'h0112, 8'h05, "R3");
        // R5 / R6: same pair of homes, recency-driven eviction
        put(13'h0112, 8'h05, 12'h222, "R5");
        look(13'h0112, 8'h05, "R6");
        put(13'h0212, 8'h05, 12'h333, "R5");
        look(13'h0012, 8'h05, "R5");
        look(13'h0112, 8'h05, "R5");
        look(13'h0212, 8'h05, "R6");
        put(13'h0312, 8'h05, 12'h444, "R6");
        look(13'h0112, 8'h05, "R6");
        look(13'h0312, 8'h05, "R6");
        // R10: overwrite in place
        put(13'h0212, 8'h05, 12'h555, "R10");
        look(13'h0212, 8'h05, "R10");
        look(13'h0312, 8'h05, "R10");
        // R11: lookup and insert of the same translation in one cycle
        step(1, 13'h0777, 8'h21, 1, 13'h0777, 8'h21, 12'h777, 0, 0, 0, "R11");
        look(13'h0777, 8'h21, "R11");
        put(13'h0036, 8'h21, 12'h666, "R4");
        look(13'h0036, 8'h21, "R4");
        // R9: space purge hides one identifier only
        step(1, 13'h0212, 8'h05, 0, 0, 0, 0, 0, 1, 8'h05, "R9");
        look(13'h0212, 8'h05, "R9");
        look(13'h0777, 8'h21, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
        look(13'h0036, 8'h21, "R9");
        idle(260, "R9");
        look(13'h0312, 8'h05, "R9");
        // R7 / R8: full purge, rejected second purge, inserts during clearing
        step(1, 13'h0777, 8'h21, 0, 0, 0, 0, 1, 0, 0, "R7");
        look(13'h0777, 8'h21, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 8'h21, "R7");
        put(13'h0a0a, 8'h4c, 12'h0aa, "R8");
        look(13'h0a0a, 8'h4c, "R8");
        idle(260, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 8'h05, "R9");
        look(13'h0777, 8'h21, "R8");
        look(13'h0036, 8'h21, "R8");
        look(13'h0a0a, 8'h4c, "R8");
        idle(260, "R8");
        // Random phase against the reference
        for (int it = 0; it < 9000; it++) begin
            logic [7:0] sids [4];
            logic [7:0] ls, ws;
            logic [12:0] lv, wv;
            bit lk, wi, pa, ps;
            sids[0] = 8'h05; sids[1] = 8'h85; sids[2] = 8'h21; sids[3] = 8'h4c;
            ls = sids[$urandom % 4]; ws = sids[$urandom % 4];
            lv = {5'($urandom), 8'($urandom % 16)};
            wv = {5'($urandom), 8'($urandom % 16)};
            lk = ($urandom % 4) != 0;
            wi = ($urandom % 3) == 0;
            if (scan_left > 0 && scan_space && ws == scan_sid) wi = 1'b0;
            pa = 1'b0; ps = 1'b0;
            if (($urandom % 400) == 0) begin
                if ($urandom % 2) pa = 1'b1; else ps = 1'b1;
            end
            step(lk, lv, ls, wi, wv, ws, 12'($urandom), pa, ps, sids[$urandom % 4], "R5");
        end
        finish_run();
    end
endmodule